// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold-Gated Interrupt

This block drives an analog-to-digital converter core through a start/done handshake and keeps it converting without pause while software leaves it enabled. Software programs it through four byte-wide registers: an enable bit, a channel number, an 8-bit threshold and a compare setting. The block holds the start request high to the core with the selected channel. Every time the core reports a finished conversion, the block stores the 10-bit result in a result register. The core then goes on to the next conversion with no idle cycle.

Each stored result can raise a single-cycle end-of-conversion interrupt. With the compare off, the interrupt fires for every result. With the compare on, it fires only when the upper eight bits of the result are at or above the threshold, or only when they are below it, depending on the direction bit. Any register write during a conversion cancels that conversion. The start request drops for one cycle and the conversion then begins again, unless the write cleared the enable bit, in which case the block goes idle. A result that software has not read is simply overwritten by the next one.

Core handshake: while `cv_start` is high the core converts, and it pulses `cv_done` with `cv_data` when it finishes. A low `cv_start` cancels the core's work in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A write of 1 to bit 0 of address 0 (enable) from the idle state drives `cv_start` high on the next cycle, with `cv_chan` equal to bits [2:0] last written to address 1.
- R2: While the block is enabled and no register is written, `cv_start` stays high across every `cv_done`, so conversions follow each other with no gap.
- R3: Writing 0 to the enable bit makes `cv_start` low on the next cycle, and it stays low with no further result updates or interrupts until the block is enabled again.
- R4: A write to any address (0 mode, 1 channel, 2 threshold, 3 compare) while a conversion is in progress leaves the enable bit set if it was set, pulls `cv_start` low for exactly one cycle and then raises it again. A `cv_done` in the cycle of that write is ignored: the result is unchanged and no interrupt is raised.
- R5: With bit 0 of address 3 (compare enable) at 0, every accepted conversion raises `irq`.
- R6: With compare enabled and bit 1 of address 3 (direction) at 0, `irq` is raised only when result[9:2] >= the threshold held at address 2.
- R7: With compare enabled and direction at 1, `irq` is raised only when result[9:2] < the threshold.
- R8: On every accepted `cv_done`, `result` takes `cv_data` in the next cycle, replacing any earlier value whether or not it was read.
- R9: `irq` is a one-cycle pulse that is high only in the cycle in which `result` has just been updated.
- R10: After reset, all registers are zero, `result` is zero, and `irq` and `cv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 channel, 2 threshold, 3 compare |
| reg_wdata | input | 8 | Register write data |
| cv_start | output | 1 | Conversion request to the core; a low level cancels |
| cv_chan | output | 3 | Channel presented to the core |
| cv_done | input | 1 | Core conversion-finished pulse |
| cv_data | input | 10 | Core conversion result, valid with `cv_done` |
| result | output | 10 | Last accepted conversion result |
| irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
A register write sampled at one clock edge changes `cv_start` one cycle later. The bench therefore expects the one-cycle low gap on `cv_start` in the cycle that follows a write made during a conversion. A `cv_done` accepted at one edge shows up on `result` and `irq` in the very next cycle, and the bench predicts that value from the `cv_done` and `cv_data` it saw just before that edge. All inputs are driven on the falling edge, and all outputs are compared 1 ns after the falling edge. Each comparison therefore checks the registered outcome of exactly the previous rising edge against the snapshot taken one cycle earlier.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_GAP  = 2'd2
    } conv_state_e;

    localparam logic [1:0] ADR_MODE = 2'd0;
    localparam logic [1:0] ADR_CHAN = 2'd1;
    localparam logic [1:0] ADR_THR  = 2'd2;
    localparam logic [1:0] ADR_CMP  = 2'd3;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [THR_W-1:0] wdata,
    output logic             en_q,
    output logic             en_nx,
    output logic [CH_W-1:0]  chan_q,
    output logic [THR_W-1:0] thr_q,
    output logic             cmp_en_q,
    output logic             cmp_lt_q
);
    typedef struct packed {
        logic             en;
        logic [CH_W-1:0]  chan;
        logic [THR_W-1:0] thr;
        logic             cmp_en;
        logic             cmp_lt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                ADR_MODE: r_d.en     = wdata[0];
                ADR_CHAN: r_d.chan   = wdata[CH_W-1:0];
                ADR_THR:  r_d.thr    = wdata;
                default: begin
                    r_d.cmp_en = wdata[0];
                    r_d.cmp_lt = wdata[1];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_q     = r_q.en;
    assign en_nx    = r_d.en;
    assign chan_q   = r_q.chan;
    assign thr_q    = r_q.thr;
    assign cmp_en_q = r_q.cmp_en;
    assign cmp_lt_q = r_q.cmp_lt;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (r_q == '0)); // R10
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic en_q,
    input  logic en_nx,
    input  logic done,
    output logic start,
    output logic accept
);
    conv_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (!en_nx)              st_d = ST_IDLE;
            else if (st_q == ST_IDLE) st_d = ST_BUSY;
            else                     st_d = ST_GAP;
        end else begin
            case (st_q)
                ST_IDLE: st_d = en_q ? ST_BUSY : ST_IDLE;
                ST_GAP:  st_d = ST_BUSY;
                default: st_d = ST_BUSY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign start  = (st_q == ST_BUSY);
    assign accept = done && (st_q == ST_BUSY) && !wr;

    AST_ABORT_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && start) |=> !start); // R4
    AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && en_q && !wr) |=> start); // R4
    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !start); // R3
    AST_RUN_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done && !wr) |=> start); // R2
endmodule

// File: rtl/adc_seq_gate.sv
module adc_seq_gate #(
    parameter int RES_W = 10,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [RES_W-1:0] data,
    input  logic [THR_W-1:0] thr,
    input  logic             cmp_en,
    input  logic             cmp_lt,
    output logic [RES_W-1:0] res_q,
    output logic             irq_q
);
    localparam int HI_LSB = RES_W - THR_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             irq;
    } gate_t;

    gate_t g_d, g_q;
    logic [THR_W-1:0] hi;
    logic             pass;

    always_comb begin
        hi   = data[RES_W-1:HI_LSB];
        pass = !cmp_en || (cmp_lt ? (hi < thr) : (hi >= thr));
        g_d      = g_q;
        g_d.irq  = 1'b0;
        if (accept) begin
            g_d.res = data;
            g_d.irq = pass;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign res_q = g_q.res;
    assign irq_q = g_q.irq;

    AST_IRQ_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(accept)); // R9
    AST_GE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && cmp_en && !cmp_lt) |-> (res_q[RES_W-1:HI_LSB] >= thr)); // R6
    AST_LT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && cmp_en && cmp_lt) |-> (res_q[RES_W-1:HI_LSB] < thr)); // R7
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (res_q == $past(res_q))); // R8
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int CH_W  = 3,
    parameter int THR_W = 8,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [THR_W-1:0] reg_wdata,
    output logic             cv_start,
    output logic [CH_W-1:0]  cv_chan,
    input  logic             cv_done,
    input  logic [RES_W-1:0] cv_data,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    logic             en_q, en_nx, cmp_en_q, cmp_lt_q, accept;
    logic [THR_W-1:0] thr_q;

    adc_seq_regs #(.CH_W(CH_W), .THR_W(THR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .en_q(en_q), .en_nx(en_nx), .chan_q(cv_chan),
        .thr_q(thr_q), .cmp_en_q(cmp_en_q), .cmp_lt_q(cmp_lt_q)
    );

    adc_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .en_q(en_q), .en_nx(en_nx),
        .done(cv_done), .start(cv_start), .accept(accept)
    );

    adc_seq_gate #(.RES_W(RES_W), .THR_W(THR_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .accept(accept), .data(cv_data),
        .thr(thr_q), .cmp_en(cmp_en_q), .cmp_lt(cmp_lt_q),
        .res_q(result), .irq_q(irq)
    );
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       cv_start, cv_done, irq;
    logic [2:0] cv_chan;
    logic [9:0] cv_data, result;

    int n_run = 0, n_fail = 0, irq_cnt = 0, cyc = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cv_start(cv_start), .cv_chan(cv_chan),
        .cv_done(cv_done), .cv_data(cv_data), .result(result), .irq(irq)
    );

    // converter core stand-in with fixed latency
    int        cnt = 0;
    logic [9:0] dval = 10'h155;
    bit        fixed_on = 0;
    logic [9:0] fixed_val = '0;
    always @(posedge clk) begin
        if (!rst_n || !cv_start) cnt <= 0;
        else if (cnt == LAT-1) begin
            cnt  <= 0;
            dval <= fixed_on ? fixed_val : 10'($urandom);
        end else cnt <= cnt + 1;
    end
    assign cv_done = cv_start && (cnt == LAT-1);
    assign cv_data = dval;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit pass_f(input logic [9:0] d, input logic [7:0] t,
                                  input bit ce, input bit lt);
        if (!ce) return 1'b1;
        return lt ? (d[9:2] < t) : (d[9:2] >= t);
    endfunction

    // reference model of the register set and expected outputs
    bit         m_en = 0, m_ce = 0, m_lt = 0;
    logic [2:0] m_chan = '0;
    logic [7:0] m_thr = '0;
    logic [9:0] exp_res = '0;
    bit         exp_irq = 0, exp_start = 0, exp_gap = 0;
    string      itag = "R9", stag = "R10";

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(result == exp_res, "R8 result", result, exp_res);
            chk(irq == exp_irq, itag, irq, exp_irq);
            chk(cv_start == exp_start, stag, cv_start, exp_start);
            if (cv_start) chk(cv_chan == m_chan, "R1 channel", cv_chan, m_chan);
            if (irq) irq_cnt++;
            begin
                bit acc, en_new, busyish;
                acc = cv_done && !reg_wr;
                if (acc) begin
                    exp_res = cv_data;
                    exp_irq = pass_f(cv_data, m_thr, m_ce, m_lt);
                    itag = !m_ce ? "R5 irq" : (m_lt ? "R7 irq" : "R6 irq");
                end else begin
                    exp_irq = 0;
                    itag = reg_wr && cv_done ? "R4 irq-ignored" : "R9 irq";
                end
                en_new = (reg_wr && reg_addr == 2'd0) ? reg_wdata[0] : m_en;
                if (reg_wr) begin
                    busyish   = cv_start || exp_gap;
                    exp_gap   = en_new && busyish;
                    exp_start = en_new && !busyish;
                    stag = !en_new ? "R3 start" : (busyish ? "R4 start" : "R1 start");
                end else begin
                    stag      = exp_gap ? "R4 restart" : (acc ? "R2 start" : "R3 start");
                    exp_start = m_en;
                    exp_gap   = 0;
                end
                if (reg_wr) begin
                    case (reg_addr)
                        2'd0: m_en   = reg_wdata[0];
                        2'd1: m_chan = reg_wdata[2:0];
                        2'd2: m_thr  = reg_wdata;
                        default: begin m_ce = reg_wdata[0]; m_lt = reg_wdata[1]; end
                    endcase
                end
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        #2;
        chk(result == 0, "R10 result", result, 0);
        chk(irq == 0, "R10 irq", irq, 0);
        chk(cv_start == 0, "R10 start", cv_start, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        chk(cv_start == 0, "R10 idle", cv_start, 0);

        // R1/R5: channel, compare off, enable
        wr_reg(2'd1, 8'd5);
        wr_reg(2'd0, 8'd1);
        #2 chk(cv_start == 1 && cv_chan == 3'd5, "R1 enable", {cv_start, cv_chan}, 4'hD);
        irq_cnt = 0;
        idle(60);
        chk(irq_cnt >= 8, "R5 every conversion", irq_cnt, 8);

        // R6: >= threshold, boundary 0x80
        fixed_on = 1; fixed_val = 10'h200;
        wr_reg(2'd2, 8'h80);
        wr_reg(2'd3, 8'h01);
        idle(10); irq_cnt = 0; idle(40);
        chk(irq_cnt > 0, "R6 equal passes", irq_cnt, 1);
        fixed_val = 10'h1FF; idle(10); irq_cnt = 0; idle(40);
        chk(irq_cnt == 0, "R6 below blocked", irq_cnt, 0);

        // R7: < threshold
        wr_reg(2'd3, 8'h03);
        idle(10); irq_cnt = 0; idle(40);
        chk(irq_cnt > 0, "R7 below passes", irq_cnt, 1);
        fixed_val = 10'h200; idle(10); irq_cnt = 0; idle(40);
        chk(irq_cnt == 0, "R7 equal blocked", irq_cnt, 0);
        fixed_on = 0;

        // R4: write in the cycle of cv_done, result kept
        wr_reg(2'd3, 8'h00);
        idle(3);
        begin
            logic [9:0] saved;
            @(negedge clk);
            while (!cv_done) @(negedge clk);
            saved = result;
            reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h11;
            @(negedge clk); reg_wr = 1'b0;
            #2;
            chk(result == saved, "R4 done ignored", result, saved);
            chk(irq == 0, "R4 no irq on abort", irq, 0);
            chk(cv_start == 0, "R4 gap", cv_start, 0);
            @(negedge clk); #2;
            chk(cv_start == 1, "R4 restart", cv_start, 1);
        end

        // R3: disable
        wr_reg(2'd0, 8'h00);
        irq_cnt = 0; idle(30);
        chk(irq_cnt == 0 && cv_start == 0, "R3 stopped", irq_cnt, 0);

        // random phase
        wr_reg(2'd0, 8'h01);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 29) == 0) begin
                logic [1:0] a;
                logic [7:0] d;
                a = 2'($urandom);
                d = 8'($urandom);
                if (a == 2'd0) d[0] = ($urandom_range(0, 9) != 0);
                reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
            end else reg_wr = 1'b0;
        end
        @(negedge clk); reg_wr = 1'b0;
        idle(5);
        finish_run();
    end
endmodule